// File: doc/BRIEF.md
# Write-Through Snooping Line Controller

This block holds the coherence state for a small direct-mapped cache that writes through and never allocates on a write. The cache sits on a shared bus that every cache can observe. Each line is either valid or invalid. A read that misses fetches the line over the bus and makes it valid. A read that hits is answered locally, with no bus traffic. Every write goes out on the bus, whether it hits or misses. Because all writes pass over the one bus, the order of the bus is the single order of writes that every cache sees.

The block also watches writes on the bus. When another requester writes a line that this cache holds as valid, the line is dropped, so the next local read fetches the new value. The data storage, the bus arbiter and main memory live outside this block. A processor request is held until the arbiter grants the bus, and the line state changes on the clock edge at which the grant is seen.

Top module: `wt_snoop_line_ctrl`

## Requirements
- R1: After an active-low asynchronous reset, every line reports invalid on `line_valid_o`.
- R2: A read whose line is invalid, or whose stored tag differs, requests a bus read (`bus_cmd_o` = 1) carrying the request address. On the edge where the grant is seen, the line becomes valid and holds that tag.
- R3: A read whose line is valid with a matching tag completes in the same cycle (`cpu_done_o` and `cpu_hit_o` high), with `bus_req_o` low.
- R4: Every write requests a bus write (`bus_cmd_o` = 2) carrying the request address. A write to an invalid line leaves that line invalid.
- R5: A write that hits a valid line leaves the line valid, with its tag unchanged.
- R6: While the bus is requested and no grant has arrived, `cpu_done_o` stays low and the line state does not change.
- R7: A snooped bus write (`snoop_cmd_i` = 2) from a requester other than `SELF_ID`, whose tag matches a valid line, makes that line invalid on the next edge.
- R8: A snooped write that carries this cache's own requester ID (`SELF_ID`) leaves every line unchanged.
- R9: A snooped write whose tag differs from the stored tag leaves the line unchanged. So does a snooped bus read, whatever its address.
- R10: Addresses split into a word offset (bits [1:0], ignored), a line index (bits [4:2]) and a tag (bits [15:5]). Two addresses with the same index and different tags compete for one line, and a read miss replaces the old tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request, held until done |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Request address |
| cpu_done_o | output | 1 | Request completes this cycle |
| cpu_hit_o | output | 1 | Request address is present and valid |
| bus_req_o | output | 1 | Bus transaction wanted |
| bus_cmd_o | output | 2 | 0 idle, 1 read, 2 write |
| bus_addr_o | output | ADDR_W | Address of own bus transaction |
| bus_gnt_i | input | 1 | Arbiter grant for own transaction |
| snoop_valid_i | input | 1 | A bus transaction is visible |
| snoop_cmd_i | input | 2 | Snooped command, same encoding |
| snoop_id_i | input | ID_W | Requester ID of the snooped transaction |
| snoop_addr_i | input | ADDR_W | Snooped address |
| line_valid_o | output | LINES | Valid bit of each line |

## Verification
On every cycle, the assertions check that a read hit stays off the bus and that every write requests a bus write. They also check that nothing completes before the grant, that a granted read miss leaves its line valid and that a write never sets a line valid. Further cycle-by-cycle properties cover lines becoming valid only through a granted fill and the cache ignoring its own snooped writes. Which line a foreign write invalidates, whether a tag mismatch or a snooped read is ignored, and whether a conflicting tag replaces a line depend on the order of events. Only the bench's scenarios show those outcomes, by comparing every line against a reference model.

// File: rtl/wtl_pkg.sv
package wtl_pkg;
  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_READ  = 2'd1,
    BUS_WRITE = 2'd2
  } bus_cmd_e;

  typedef enum logic {
    LINE_INV = 1'b0,
    LINE_VAL = 1'b1
  } line_state_e;
endpackage

// File: rtl/wtl_line_array.sv
module wtl_line_array #(
  parameter int IDX_W = 3,
  parameter int TAG_W = 11,
  localparam int LINES = 1 << IDX_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        fill_en_i,
  input  logic [IDX_W-1:0]            fill_idx_i,
  input  logic [TAG_W-1:0]            fill_tag_i,
  input  logic                        inv_en_i,
  input  logic [IDX_W-1:0]            inv_idx_i,
  output logic [LINES-1:0]            valid_o,
  output logic [LINES-1:0][TAG_W-1:0] tag_o
);
  import wtl_pkg::*;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_state_e       state_q;
    logic [TAG_W-1:0]  tag_q;
    logic              fill_hit, inv_hit;

    assign fill_hit = fill_en_i && (fill_idx_i == IDX_W'(g));
    assign inv_hit  = inv_en_i  && (inv_idx_i  == IDX_W'(g));

    // a local fill wins over a same-cycle snoop invalidate
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        state_q <= LINE_INV;
        tag_q   <= '0;
      end else if (fill_hit) begin
        state_q <= LINE_VAL;
        tag_q   <= fill_tag_i;
      end else if (inv_hit) begin
        state_q <= LINE_INV;
      end
    end

    assign valid_o[g] = (state_q == LINE_VAL);
    assign tag_o[g]   = tag_q;
  end
endmodule

// File: rtl/wtl_proc_ctrl.sv
module wtl_proc_ctrl (
  input  logic               req_i,
  input  logic               we_i,
  input  logic               hit_i,
  input  logic               gnt_i,
  output logic               bus_req_o,
  output wtl_pkg::bus_cmd_e  bus_cmd_o,
  output logic               done_o,
  output logic               fill_en_o
);
  import wtl_pkg::*;

  always_comb begin
    bus_req_o = 1'b0;
    bus_cmd_o = BUS_IDLE;
    done_o    = 1'b0;
    fill_en_o = 1'b0;
    if (req_i) begin
      if (we_i) begin
        // write-through, never allocates
        bus_req_o = 1'b1;
        bus_cmd_o = BUS_WRITE;
        done_o    = gnt_i;
      end else if (hit_i) begin
        done_o    = 1'b1;
      end else begin
        bus_req_o = 1'b1;
        bus_cmd_o = BUS_READ;
        done_o    = gnt_i;
        fill_en_o = gnt_i;
      end
    end
  end
endmodule

// File: rtl/wtl_snoop_match.sv
module wtl_snoop_match #(
  parameter int IDX_W = 3,
  parameter int TAG_W = 11,
  parameter int ID_W  = 2,
  parameter logic [ID_W-1:0] SELF_ID = '0,
  localparam int LINES = 1 << IDX_W
) (
  input  logic                        snoop_valid_i,
  input  logic [1:0]                  snoop_cmd_i,
  input  logic [ID_W-1:0]             snoop_id_i,
  input  logic [IDX_W-1:0]            snoop_idx_i,
  input  logic [TAG_W-1:0]            snoop_tag_i,
  input  logic [LINES-1:0]            valid_i,
  input  logic [LINES-1:0][TAG_W-1:0] tag_i,
  output logic                        inv_en_o,
  output logic [IDX_W-1:0]            inv_idx_o
);
  import wtl_pkg::*;

  logic foreign_wr;
  assign foreign_wr = snoop_valid_i && (snoop_cmd_i == BUS_WRITE) && (snoop_id_i != SELF_ID);
  assign inv_en_o   = foreign_wr && valid_i[snoop_idx_i] && (tag_i[snoop_idx_i] == snoop_tag_i);
  assign inv_idx_o  = snoop_idx_i;
endmodule

// File: rtl/wt_snoop_line_ctrl.sv
module wt_snoop_line_ctrl #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 2,
  parameter int IDX_W  = 3,
  parameter int ID_W   = 2,
  parameter logic [ID_W-1:0] SELF_ID = 2'd1,
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
  localparam int LINES = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  output logic              cpu_done_o,
  output logic              cpu_hit_o,
  output logic              bus_req_o,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  input  logic              bus_gnt_i,
  input  logic              snoop_valid_i,
  input  logic [1:0]        snoop_cmd_i,
  input  logic [ID_W-1:0]   snoop_id_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  output logic [LINES-1:0]  line_valid_o
);
  import wtl_pkg::*;

  logic [IDX_W-1:0]            cpu_idx, snp_idx, inv_idx;
  logic [TAG_W-1:0]            cpu_tag, snp_tag;
  logic [LINES-1:0]            valid;
  logic [LINES-1:0][TAG_W-1:0] tags;
  logic                        lookup_hit, fill_en, inv_en;
  bus_cmd_e                    cmd;

  assign cpu_idx = cpu_addr_i[OFF_W +: IDX_W];
  assign cpu_tag = cpu_addr_i[ADDR_W-1 -: TAG_W];
  assign snp_idx = snoop_addr_i[OFF_W +: IDX_W];
  assign snp_tag = snoop_addr_i[ADDR_W-1 -: TAG_W];

  assign lookup_hit = valid[cpu_idx] && (tags[cpu_idx] == cpu_tag);

  wtl_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) i_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fill_en_i  (fill_en),
    .fill_idx_i (cpu_idx),
    .fill_tag_i (cpu_tag),
    .inv_en_i   (inv_en),
    .inv_idx_i  (inv_idx),
    .valid_o    (valid),
    .tag_o      (tags)
  );

  wtl_proc_ctrl i_proc (
    .req_i     (cpu_req_i),
    .we_i      (cpu_we_i),
    .hit_i     (lookup_hit),
    .gnt_i     (bus_gnt_i),
    .bus_req_o (bus_req_o),
    .bus_cmd_o (cmd),
    .done_o    (cpu_done_o),
    .fill_en_o (fill_en)
  );

  wtl_snoop_match #(
    .IDX_W(IDX_W), .TAG_W(TAG_W), .ID_W(ID_W), .SELF_ID(SELF_ID)
  ) i_snoop (
    .snoop_valid_i (snoop_valid_i),
    .snoop_cmd_i   (snoop_cmd_i),
    .snoop_id_i    (snoop_id_i),
    .snoop_idx_i   (snp_idx),
    .snoop_tag_i   (snp_tag),
    .valid_i       (valid),
    .tag_i         (tags),
    .inv_en_o      (inv_en),
    .inv_idx_o     (inv_idx)
  );

  assign bus_cmd_o    = cmd;
  assign bus_addr_o   = cpu_addr_i;
  assign cpu_hit_o    = cpu_req_i && lookup_hit;
  assign line_valid_o = valid;
endmodule

// File: rtl/wtl_checker.sv
module wtl_checker #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 2,
  parameter int IDX_W  = 3,
  parameter int ID_W   = 2,
  parameter logic [ID_W-1:0] SELF_ID = 2'd1,
  localparam int LINES = 1 << IDX_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_i,
  input logic              cpu_we_i,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic              cpu_done_o,
  input logic              cpu_hit_o,
  input logic              bus_req_o,
  input logic [1:0]        bus_cmd_o,
  input logic              bus_gnt_i,
  input logic              snoop_valid_i,
  input logic [ID_W-1:0]   snoop_id_i,
  input logic [LINES-1:0]  line_valid_o
);
  logic [IDX_W-1:0] idx;
  logic             granted;
  assign idx     = cpu_addr_i[OFF_W +: IDX_W];
  assign granted = bus_req_o && bus_gnt_i;

  p_read_hit_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && !cpu_we_i && cpu_hit_o |-> !bus_req_o && cpu_done_o);

  p_write_on_bus_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && cpu_we_i |-> bus_req_o && bus_cmd_o == 2'd2);

  p_no_alloc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && cpu_we_i && !line_valid_o[idx] |=> !line_valid_o[$past(idx)]);

  p_wait_grant_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_gnt_i |-> !cpu_done_o);

  p_fill_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && !cpu_we_i && granted |=> line_valid_o[$past(idx)]);

  p_grow_on_fill_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(line_valid_o) > $countones($past(line_valid_o)) |-> $past(granted && !cpu_we_i));

  p_own_snoop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_valid_i && snoop_id_i == SELF_ID && !granted |=> $stable(line_valid_o));
endmodule

bind wt_snoop_line_ctrl wtl_checker #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ID_W(ID_W), .SELF_ID(SELF_ID)
) i_wtl_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cpu_req_i     (cpu_req_i),
  .cpu_we_i      (cpu_we_i),
  .cpu_addr_i    (cpu_addr_i),
  .cpu_done_o    (cpu_done_o),
  .cpu_hit_o     (cpu_hit_o),
  .bus_req_o     (bus_req_o),
  .bus_cmd_o     (bus_cmd_o),
  .bus_gnt_i     (bus_gnt_i),
  .snoop_valid_i (snoop_valid_i),
  .snoop_id_i    (snoop_id_i),
  .line_valid_o  (line_valid_o)
);

// File: tb/test_wt_snoop_line_ctrl.sv
module test_wt_snoop_line_ctrl;
  localparam int ADDR_W = 16;
  localparam int LINES  = 8;
  localparam logic [1:0] SELF = 2'd1;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cpu_req_i = 1'b0, cpu_we_i = 1'b0;
  logic [ADDR_W-1:0] cpu_addr_i = '0;
  logic              cpu_done_o, cpu_hit_o, bus_req_o;
  logic [1:0]        bus_cmd_o;
  logic [ADDR_W-1:0] bus_addr_o;
  logic              bus_gnt_i = 1'b0;
  logic              snoop_valid_i = 1'b0;
  logic [1:0]        snoop_cmd_i = '0, snoop_id_i = '0;
  logic [ADDR_W-1:0] snoop_addr_i = '0;
  logic [LINES-1:0]  line_valid_o;

  always #2 clk_i = ~clk_i;

  wt_snoop_line_ctrl i_wt_snoop_line_ctrl (.*);

  int n_run = 0, n_fail = 0;
  logic [17:0] exp_q[$];
  logic [LINES-1:0] mv = '0;
  logic [10:0]      mt [LINES];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic [10:0] tag, input logic [2:0] idx);
    return {tag, idx, 2'b00};
  endfunction

  // monitor: every granted bus transaction is compared with the scoreboard
  always @(negedge clk_i) begin
    #1;
    if (rst_ni && bus_req_o && bus_gnt_i) begin
      if (exp_q.size() == 0) chk(0, "R2/R4 unexpected bus op", int'({bus_cmd_o, bus_addr_o}), 0);
      else begin
        logic [17:0] e;
        e = exp_q.pop_front();
        chk({bus_cmd_o, bus_addr_o} == e, "R2/R4 bus op", int'({bus_cmd_o, bus_addr_o}), int'(e));
      end
    end
  end

  task automatic cpu_op(input bit we, input logic [15:0] a, input int dly);
    logic [2:0] idx;
    logic [10:0] tag;
    bit hit;
    idx = a[4:2]; tag = a[15:5];
    hit = mv[idx] && mt[idx] == tag;
    @(negedge clk_i);
    cpu_req_i = 1'b1; cpu_we_i = we; cpu_addr_i = a; bus_gnt_i = 1'b0;
    if (we || !hit) begin
      exp_q.push_back({we ? 2'd2 : 2'd1, a});
      for (int i = 0; i < dly; i++) begin
        #1;
        chk(!cpu_done_o && bus_req_o, "R6 waiting for grant", int'(cpu_done_o), 0);
        @(negedge clk_i);
        chk(line_valid_o == mv, "R6 state frozen", int'(line_valid_o), int'(mv));
      end
      bus_gnt_i = 1'b1;
      #1;
      chk(cpu_done_o, "R2/R4 done on grant", int'(cpu_done_o), 1);
    end else begin
      #1;
      chk(cpu_done_o && cpu_hit_o && !bus_req_o, "R3 read hit local",
          int'({cpu_done_o, cpu_hit_o, bus_req_o}), 3'b110);
    end
    @(negedge clk_i);
    cpu_req_i = 1'b0; bus_gnt_i = 1'b0;
    if (!we && !hit) begin mv[idx] = 1'b1; mt[idx] = tag; end
  endtask

  task automatic snoop(input logic [1:0] id, input logic [1:0] cmd, input logic [15:0] a);
    @(negedge clk_i);
    snoop_valid_i = 1'b1; snoop_id_i = id; snoop_cmd_i = cmd; snoop_addr_i = a;
    @(negedge clk_i);
    snoop_valid_i = 1'b0;
    if (cmd == 2'd2 && id != SELF && mv[a[4:2]] && mt[a[4:2]] == a[15:5]) mv[a[4:2]] = 1'b0;
  endtask

  task automatic chk_state(input string req);
    #1;
    chk(line_valid_o == mv, req, int'(line_valid_o), int'(mv));
  endtask

  initial begin
    #10000000;
    chk(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < LINES; i++) mt[i] = '0;
    #1 chk(line_valid_o == '0, "R1 reset invalid", int'(line_valid_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk_state("R1 invalid after reset");

    cpu_op(0, mk(11'h005, 3'd1), 2);               // R2 read miss with delayed grant
    chk_state("R2 line valid after fill");
    cpu_op(0, mk(11'h005, 3'd1) | 16'h3, 0);       // R3 hit, offset ignored
    cpu_op(1, mk(11'h005, 3'd1), 1);               // R5 write hit
    chk_state("R5 write hit keeps valid");
    cpu_op(1, mk(11'h033, 3'd2), 0);               // R4 write miss, no allocate
    chk_state("R4 write miss stays invalid");
    chk(!line_valid_o[2], "R4 no allocate", int'(line_valid_o[2]), 0);

    snoop(SELF, 2'd2, mk(11'h005, 3'd1));
    chk_state("R8 own write ignored");
    chk(line_valid_o[1], "R8 line kept", int'(line_valid_o[1]), 1);
    snoop(2'd2, 2'd2, mk(11'h006, 3'd1));
    chk_state("R9 tag mismatch ignored");
    snoop(2'd3, 2'd1, mk(11'h005, 3'd1));
    chk_state("R9 snooped read ignored");
    chk(line_valid_o[1], "R9 line kept", int'(line_valid_o[1]), 1);
    snoop(2'd0, 2'd2, mk(11'h005, 3'd1));
    chk_state("R7 foreign write invalidates");
    chk(!line_valid_o[1], "R7 line dropped", int'(line_valid_o[1]), 0);
    cpu_op(0, mk(11'h005, 3'd1), 0);               // R7 re-fetch after invalidate

    cpu_op(0, mk(11'h2AA, 3'd1), 1);               // R10 conflicting tag replaces
    cpu_op(0, mk(11'h2AA, 3'd1), 0);               // R10 new tag hits
    cpu_op(0, mk(11'h005, 3'd1), 0);               // R10 old tag misses again
    chk_state("R10 replacement");

    for (int i = 0; i < LINES; i++) cpu_op(0, mk(11'(i + 16), 3'(i)), i % 3);
    chk_state("R2 all lines filled");
    for (int i = 0; i < LINES; i += 2) snoop(2'd3, 2'd2, mk(11'(i + 16), 3'(i)));
    chk_state("R7 even lines invalidated");
    chk(line_valid_o == 8'hAA, "R7 pattern", int'(line_valid_o), 8'hAA);
    for (int i = 0; i < LINES; i++) cpu_op(1, mk(11'(i + 16), 3'(i)), 0);
    chk_state("R4/R5 writes keep state");

    repeat (2) @(negedge clk_i);
    chk(exp_q.size() == 0, "R2/R4 scoreboard drained", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule